// File: doc/BRIEF.md
# Programmable LCD Timing Generator

This block produces the horizontal sync, vertical sync, data-enable and pixel-data stream for a parallel RGB panel. Two counters walk through each line and each frame. A line runs in this order: a one-clock sync pulse, then the porch that separates sync from active pixels, then the active pixels, then the porch that precedes the next sync. A frame follows the same order, counted in lines. Every size comes from packed 32-bit configuration words. The line and frame totals are derived from those words, so the totals never have to be written separately.

During the active window the block passes the incoming pixel through to the panel and reports the pixel and line position. Outside that window it drives a programmable blank colour. A small control word enables the panel and sets the polarity of each signal. The same word also picks which edge of vertical sync raises a one-clock event pulse. A frame counter advances at the end of every frame. Timing words are captured into shadow registers at frame boundaries, so a frame never mixes two geometries.

Top module: `lcd_timing_gen`

## Requirements
- R1: Each geometry word carries the vertical quantity in bits 31..16 and the horizontal quantity in bits 15..0. In each porch word, bits 31..16 hold the porch just before sync, and bits 15..0 hold the porch between sync and the first active pixel.
- R2: A line lasts active + upper porch + lower porch + 1 clocks, in this order: sync, lower porch, active pixels, upper porch. A frame lasts the same sum counted in lines, in the same order. `de_o` is asserted exactly on pixels that are active both horizontally and vertically.
- R3: HSYNC is asserted for exactly one clock at the start of each line. VSYNC is asserted for the whole first line of each frame.
- R4: Control bits: bit 0 enables the panel; bit 1 inverts HSYNC; bit 2 inverts VSYNC; bit 3 inverts DE; bit 4 is presented on `pclk_inv_o` as the pixel-clock inversion request; bit 5 selects the VSYNC event edge. An inversion bit XORs the asserted-high signal.
- R5: While DE is asserted, `pos_x_o` counts from 0 to horizontal active - 1 along the line and `pos_y_o` holds the active line index. Both are 0 outside the active window.
- R6: `rgb_o` carries `pix_rgb_i` during active pixels and `blank_rgb_i` everywhere else, including while disabled.
- R7: `frame_cnt_o` increments by one at the end of every complete frame and wraps at its width.
- R8: While bit 0 of the control word is low, the counters and the frame counter stay at 0. Sync and DE sit at their inactive levels, the event pulse stays low, and a new enable starts with a sync clock.
- R9: Changes to the geometry words take effect at the first clock of the next frame. While disabled, the live values are used directly.
- R10: `vsync_evt_o` pulses for one clock when asserted VSYNC begins (bit 5 = 0) or ends (bit 5 = 1).
- R11: Every output is registered, one clock after the counter state it reflects. A synchronous reset forces every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_active_i | input | 32 | Active lines (31..16) and active pixels (15..0) |
| cfg_hporch_i | input | 32 | Horizontal porch before sync (31..16), sync-to-active porch (15..0) |
| cfg_vporch_i | input | 32 | Vertical porch before sync (31..16), sync-to-active porch (15..0) |
| cfg_ctrl_i | input | 6 | Enable, polarity and event-edge control bits |
| blank_rgb_i | input | 24 | Colour driven outside the active window |
| pix_rgb_i | input | 24 | Incoming pixel for the current position |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| de_o | output | 1 | Data enable, polarity applied |
| pclk_inv_o | output | 1 | Registered pixel-clock inversion request |
| rgb_o | output | 24 | Pixel data to the panel |
| pos_x_o | output | 16 | Active pixel index |
| pos_y_o | output | 16 | Active line index |
| frame_cnt_o | output | 16 | Completed-frame count |
| vsync_evt_o | output | 1 | One-clock pulse on the selected VSYNC edge |

## Verification
The properties assume that the horizontal active width is at least one pixel, so a line has at least two clocks and no sync pulse can merge with the next one. They also assume that the event-edge bit does not toggle during a vertical sync. The stimulus only uses geometries with a non-zero active width, including cases where both porches are zero. It changes the polarity and edge bits only at points where the checker's one-cycle property guards stay valid. Geometry changes are made in the middle of a frame on purpose, so the comparison against the reference model shows whether the old frame completes unchanged.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;

  // Fixed by the 32-bit word packing: two 16-bit halves per word.
  localparam int FIELD_W = 16;
  localparam int CNT_W   = FIELD_W + 2;   // room for act + pre + post
  localparam int AXES    = 2;             // 0: horizontal, 1: vertical
  localparam int CTRL_W  = 6;

  // Control word bit positions.
  localparam int CB_EN       = 0;
  localparam int CB_HS_INV   = 1;
  localparam int CB_VS_INV   = 2;
  localparam int CB_DE_INV   = 3;
  localparam int CB_CK_INV   = 4;
  localparam int CB_EVT_TAIL = 5;

  // Geometry of one axis.
  typedef struct packed {
    logic [FIELD_W-1:0] act;    // active pixels or lines
    logic [FIELD_W-1:0] pre;    // porch ahead of sync (upper half)
    logic [FIELD_W-1:0] post;   // porch from sync to active (lower half)
  } axis_cfg_t;

endpackage

// File: rtl/lcd_tg_axis.sv
module lcd_tg_axis
  import lcd_tg_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               step,
  input  axis_cfg_t          cfg,
  output logic               sync_o,
  output logic               act_o,
  output logic               last_o,
  output logic [FIELD_W-1:0] pos_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_val;
  logic [CNT_W-1:0] act_lo;
  logic [CNT_W-1:0] act_hi;

  // Period is act + pre + post + 1, so the final count is the plain sum.
  always_comb begin
    last_val = CNT_W'(cfg.act) + CNT_W'(cfg.pre) + CNT_W'(cfg.post);
    act_lo   = CNT_W'(cfg.post) + CNT_W'(1);
    act_hi   = act_lo + CNT_W'(cfg.act);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
    end else if (step) begin
      if (cnt_q == last_val) cnt_q <= '0;
      else                   cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_comb begin
    sync_o = (cnt_q == '0);
    act_o  = (cnt_q >= act_lo) && (cnt_q < act_hi);
    last_o = (cnt_q == last_val);
    pos_o  = FIELD_W'(cnt_q - act_lo);
  end

endmodule

// File: rtl/lcd_tg_shadow.sv
module lcd_tg_shadow
  import lcd_tg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 frame_end,
  input  axis_cfg_t [AXES-1:0] live_i,
  output axis_cfg_t [AXES-1:0] cur_o
);

  // Tracks the live words while idle; otherwise reloads only as the
  // last clock of a frame retires, so the next frame sees one geometry.
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_o <= '0;
    end else if (!en || frame_end) begin
      cur_o <= live_i;
    end
  end

endmodule

// File: rtl/lcd_tg_outreg.sv
module lcd_tg_outreg
  import lcd_tg_pkg::*;
#(
  parameter int RGB_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               hs_raw,
  input  logic               vs_raw,
  input  logic               de_raw,
  input  logic [CTRL_W-1:0]  ctrl,
  input  logic [FIELD_W-1:0] x_in,
  input  logic [FIELD_W-1:0] y_in,
  input  logic [RGB_W-1:0]   pix,
  input  logic [RGB_W-1:0]   blank,
  output logic               hs_o,
  output logic               vs_o,
  output logic               de_o,
  output logic               ck_inv_o,
  output logic [RGB_W-1:0]   rgb_o,
  output logic [FIELD_W-1:0] x_o,
  output logic [FIELD_W-1:0] y_o,
  output logic               evt_o
);

  logic hs_on;
  logic vs_on;
  logic de_on;
  logic vs_prev_q;
  logic edge_hit;

  always_comb begin
    hs_on = en && hs_raw;
    vs_on = en && vs_raw;
    de_on = en && de_raw;
    if (ctrl[CB_EVT_TAIL]) edge_hit = vs_prev_q && !vs_on;
    else                   edge_hit = !vs_prev_q && vs_on;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_o      <= 1'b0;
      vs_o      <= 1'b0;
      de_o      <= 1'b0;
      ck_inv_o  <= 1'b0;
      rgb_o     <= '0;
      x_o       <= '0;
      y_o       <= '0;
      evt_o     <= 1'b0;
      vs_prev_q <= 1'b0;
    end else begin
      hs_o      <= hs_on ^ ctrl[CB_HS_INV];
      vs_o      <= vs_on ^ ctrl[CB_VS_INV];
      de_o      <= de_on ^ ctrl[CB_DE_INV];
      ck_inv_o  <= ctrl[CB_CK_INV];
      rgb_o     <= de_on ? pix : blank;
      x_o       <= de_on ? x_in : '0;
      y_o       <= de_on ? y_in : '0;
      evt_o     <= en && edge_hit;
      vs_prev_q <= vs_on;
    end
  end

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_tg_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int RGB_W   = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [31:0]        cfg_active_i,
  input  logic [31:0]        cfg_hporch_i,
  input  logic [31:0]        cfg_vporch_i,
  input  logic [CTRL_W-1:0]  cfg_ctrl_i,
  input  logic [RGB_W-1:0]   blank_rgb_i,
  input  logic [RGB_W-1:0]   pix_rgb_i,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic               de_o,
  output logic               pclk_inv_o,
  output logic [RGB_W-1:0]   rgb_o,
  output logic [FIELD_W-1:0] pos_x_o,
  output logic [FIELD_W-1:0] pos_y_o,
  output logic [FRAME_W-1:0] frame_cnt_o,
  output logic               vsync_evt_o
);

  localparam int HI = 2 * FIELD_W - 1;
  localparam int LO = FIELD_W - 1;

  logic                 panel_en;
  logic                 frame_end;
  axis_cfg_t [AXES-1:0] live_cfg;
  axis_cfg_t [AXES-1:0] cur_cfg;
  logic [AXES-1:0]      step;
  logic [AXES-1:0]      sync;
  logic [AXES-1:0]      act;
  logic [AXES-1:0]      last;
  logic [FIELD_W-1:0]   pos [AXES];

  assign panel_en = cfg_ctrl_i[CB_EN];

  // Horizontal quantities are in the low half of each word, vertical in the high half.
  assign live_cfg[0] = '{act:  cfg_active_i[LO:0],
                         pre:  cfg_hporch_i[HI:FIELD_W],
                         post: cfg_hporch_i[LO:0]};
  assign live_cfg[1] = '{act:  cfg_active_i[HI:FIELD_W],
                         pre:  cfg_vporch_i[HI:FIELD_W],
                         post: cfg_vporch_i[LO:0]};

  lcd_tg_shadow u_shadow (
    .clk       (clk),
    .rst       (rst),
    .en        (panel_en),
    .frame_end (frame_end),
    .live_i    (live_cfg),
    .cur_o     (cur_cfg)
  );

  // The pixel axis advances every clock; the line axis advances when a line wraps.
  assign step[0] = 1'b1;
  assign step[1] = last[0];

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    lcd_tg_axis u_axis (
      .clk    (clk),
      .rst    (rst),
      .en     (panel_en),
      .step   (step[a]),
      .cfg    (cur_cfg[a]),
      .sync_o (sync[a]),
      .act_o  (act[a]),
      .last_o (last[a]),
      .pos_o  (pos[a])
    );
  end

  assign frame_end = panel_en && last[0] && last[1];

  always_ff @(posedge clk) begin
    if (rst || !panel_en)  frame_cnt_o <= '0;
    else if (frame_end)    frame_cnt_o <= frame_cnt_o + FRAME_W'(1);
  end

  lcd_tg_outreg #(.RGB_W(RGB_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .en       (panel_en),
    .hs_raw   (sync[0]),
    .vs_raw   (sync[1]),
    .de_raw   (act[0] && act[1]),
    .ctrl     (cfg_ctrl_i),
    .x_in     (pos[0]),
    .y_in     (pos[1]),
    .pix      (pix_rgb_i),
    .blank    (blank_rgb_i),
    .hs_o     (hsync_o),
    .vs_o     (vsync_o),
    .de_o     (de_o),
    .ck_inv_o (pclk_inv_o),
    .rgb_o    (rgb_o),
    .x_o      (pos_x_o),
    .y_o      (pos_y_o),
    .evt_o    (vsync_evt_o)
  );

endmodule

// File: rtl/lcd_tg_checker.sv
module lcd_tg_checker
  import lcd_tg_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int RGB_W   = 24
) (
  input logic               clk,
  input logic               rst,
  input logic [31:0]        cfg_active_i,
  input logic [31:0]        cfg_hporch_i,
  input logic [31:0]        cfg_vporch_i,
  input logic [CTRL_W-1:0]  cfg_ctrl_i,
  input logic [RGB_W-1:0]   blank_rgb_i,
  input logic [RGB_W-1:0]   pix_rgb_i,
  input logic               hsync_o,
  input logic               vsync_o,
  input logic               de_o,
  input logic               pclk_inv_o,
  input logic [RGB_W-1:0]   rgb_o,
  input logic [FIELD_W-1:0] pos_x_o,
  input logic [FIELD_W-1:0] pos_y_o,
  input logic [FRAME_W-1:0] frame_cnt_o,
  input logic               vsync_evt_o
);

  logic [1:0]        arm_q;
  logic              armed;
  logic [CTRL_W-1:0] ctrl_q;
  logic [CTRL_W-1:0] ctrl_qq;
  logic [RGB_W-1:0]  blank_q;

  always_ff @(posedge clk) begin
    if (rst) arm_q <= '0;
    else if (arm_q != 2'd3) arm_q <= arm_q + 2'd1;
    ctrl_q  <= cfg_ctrl_i;
    ctrl_qq <= ctrl_q;
    blank_q <= blank_rgb_i;
  end
  assign armed = arm_q >= 2'd2;

  // R3: a horizontal sync pulse never lasts two clocks.
  assert_hsync_single_R3: assert property (@(posedge clk) disable iff (rst)
    armed && (hsync_o ^ ctrl_q[CB_HS_INV]) |=> !(hsync_o ^ ctrl_q[CB_HS_INV]));

  // R8: idle panel keeps outputs at their inactive levels.
  assert_disabled_idle_R8: assert property (@(posedge clk) disable iff (rst)
    armed && !ctrl_q[CB_EN] |->
      (hsync_o == ctrl_q[CB_HS_INV]) && (vsync_o == ctrl_q[CB_VS_INV]) &&
      (de_o == ctrl_q[CB_DE_INV]) && (frame_cnt_o == '0) && !vsync_evt_o &&
      (pos_x_o == '0) && (pos_y_o == '0));

  // R10: the event is a single-clock pulse.
  assert_evt_single_R10: assert property (@(posedge clk) disable iff (rst)
    armed && vsync_evt_o |=>
      (!vsync_evt_o || (ctrl_q[CB_EVT_TAIL] != ctrl_qq[CB_EVT_TAIL])));

  // R7: the frame count moves only by one or back to zero.
  assert_frame_step_R7: assert property (@(posedge clk) disable iff (rst)
    armed && (frame_cnt_o != $past(frame_cnt_o)) |->
      (frame_cnt_o == $past(frame_cnt_o) + FRAME_W'(1)) || (frame_cnt_o == '0));

  // R5: consecutive active pixels advance the x position by one.
  assert_x_steps_R5: assert property (@(posedge clk) disable iff (rst)
    armed && (ctrl_q == ctrl_qq) && (de_o ^ ctrl_q[CB_DE_INV]) &&
    ($past(de_o) ^ ctrl_qq[CB_DE_INV]) |->
      pos_x_o == $past(pos_x_o) + FIELD_W'(1));

  // R6: outside the active window the blank colour is driven.
  assert_blank_R6: assert property (@(posedge clk) disable iff (rst)
    armed && !(de_o ^ ctrl_q[CB_DE_INV]) |-> rgb_o == blank_q);

endmodule

bind lcd_timing_gen lcd_tg_checker #(.FRAME_W(FRAME_W), .RGB_W(RGB_W)) u_chk (.*);

// File: tb/lcd_timing_gen_bench.sv
`timescale 1ns/1ps
module lcd_timing_gen_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cfg_active = '0;
  logic [31:0] cfg_hporch = '0;
  logic [31:0] cfg_vporch = '0;
  logic [5:0]  cfg_ctrl = '0;
  logic [23:0] blank_rgb = 24'hFF00FF;
  logic [23:0] pix_rgb = 24'h000001;

  logic        hsync, vsync, de, pclk_inv, vsync_evt;
  logic [23:0] rgb;
  logic [15:0] pos_x, pos_y, frame_cnt;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string phase = "R2";

  always #2.5 clk = ~clk;

  lcd_timing_gen u_lcd_timing_gen (
    .clk(clk), .rst(rst),
    .cfg_active_i(cfg_active), .cfg_hporch_i(cfg_hporch), .cfg_vporch_i(cfg_vporch),
    .cfg_ctrl_i(cfg_ctrl), .blank_rgb_i(blank_rgb), .pix_rgb_i(pix_rgb),
    .hsync_o(hsync), .vsync_o(vsync), .de_o(de), .pclk_inv_o(pclk_inv),
    .rgb_o(rgb), .pos_x_o(pos_x), .pos_y_o(pos_y),
    .frame_cnt_o(frame_cnt), .vsync_evt_o(vsync_evt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s] actual=%0h expected=%0h at %0t", req, phase, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced at every rising edge.
  int m_hc, m_vc, s_ha, s_hpre, s_hpost, s_va, s_vpre, s_vpost;
  bit m_vsp, m_valid;
  logic [15:0] m_frame;
  logic e_hs, e_vs, e_de, e_ck, e_evt;
  logic [23:0] e_rgb;
  logic [15:0] e_x, e_y, e_frame;

  always @(posedge clk) begin
    int th, tv;
    bit en, hsn, vsn, hin, vin, den, eof;
    if (rst) begin
      m_hc = 0; m_vc = 0; m_vsp = 0; m_frame = 0;
      s_ha = 0; s_hpre = 0; s_hpost = 0; s_va = 0; s_vpre = 0; s_vpost = 0;
      e_hs = 0; e_vs = 0; e_de = 0; e_ck = 0; e_evt = 0;
      e_rgb = 0; e_x = 0; e_y = 0; e_frame = 0;
    end else begin
      en  = cfg_ctrl[0];
      th  = s_ha + s_hpre + s_hpost + 1;
      tv  = s_va + s_vpre + s_vpost + 1;
      hsn = en && (m_hc == 0);
      vsn = en && (m_vc == 0);
      hin = (m_hc >= 1 + s_hpost) && (m_hc < 1 + s_hpost + s_ha);
      vin = (m_vc >= 1 + s_vpost) && (m_vc < 1 + s_vpost + s_va);
      den = en && hin && vin;
      e_hs  = hsn ^ cfg_ctrl[1];
      e_vs  = vsn ^ cfg_ctrl[2];
      e_de  = den ^ cfg_ctrl[3];
      e_ck  = cfg_ctrl[4];
      e_x   = den ? 16'(m_hc - 1 - s_hpost) : 16'd0;
      e_y   = den ? 16'(m_vc - 1 - s_vpost) : 16'd0;
      e_rgb = den ? pix_rgb : blank_rgb;
      e_evt = en && (cfg_ctrl[5] ? (m_vsp && !vsn) : (!m_vsp && vsn));
      m_vsp = vsn;
      eof = en && (m_hc == th - 1) && (m_vc == tv - 1);
      if (!en) m_frame = 0;
      else if (eof) m_frame = m_frame + 16'd1;
      e_frame = m_frame;
      if (!en) begin
        m_hc = 0; m_vc = 0;
      end else if (m_hc == th - 1) begin
        m_hc = 0;
        m_vc = (m_vc == tv - 1) ? 0 : m_vc + 1;
      end else begin
        m_hc = m_hc + 1;
      end
      if (!en || eof) begin
        s_ha = cfg_active[15:0];  s_va = cfg_active[31:16];
        s_hpre = cfg_hporch[31:16]; s_hpost = cfg_hporch[15:0];
        s_vpre = cfg_vporch[31:16]; s_vpost = cfg_vporch[15:0];
      end
    end
    m_valid = 1;
  end

  // Compare every output away from the active edge.
  always @(negedge clk) begin
    if (m_valid && !done) begin
      chk("R1 R2 R3 R4 hsync", {31'd0, hsync}, {31'd0, e_hs});
      chk("R1 R3 R4 vsync", {31'd0, vsync}, {31'd0, e_vs});
      chk("R1 R2 R4 de", {31'd0, de}, {31'd0, e_de});
      chk("R4 pclk_inv", {31'd0, pclk_inv}, {31'd0, e_ck});
      chk("R5 pos_x", {16'd0, pos_x}, {16'd0, e_x});
      chk("R5 pos_y", {16'd0, pos_y}, {16'd0, e_y});
      chk("R6 rgb", {8'd0, rgb}, {8'd0, e_rgb});
      chk("R7 frame_cnt", {16'd0, frame_cnt}, {16'd0, e_frame});
      chk("R10 vsync_evt", {31'd0, vsync_evt}, {31'd0, e_evt});
    end
  end

  task automatic set_geom(input int ha, hpre, hpost, va, vpre, vpost);
    cfg_active = {16'(va), 16'(ha)};
    cfg_hporch = {16'(hpre), 16'(hpost)};
    cfg_vporch = {16'(vpre), 16'(vpost)};
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      pix_rgb = pix_rgb + 24'h010203;
    end
  end

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    set_geom(6, 3, 2, 4, 2, 1);     // line of 12 clocks, frame of 8 lines
    run(4);
    // R11: reset state of every output
    phase = "R11";
    chk("R11 reset outputs", {hsync, vsync, de, pclk_inv, vsync_evt, 27'd0}, 32'd0);
    chk("R11 reset rgb/x", {rgb, pos_x[7:0]}, 32'd0);
    rst = 1'b0;
    run(5);
    phase = "R8 idle";
    run(10);
    phase = "R2 R3 base";
    cfg_ctrl = 6'b000001;
    run(96 * 3);
    chk("R7 three frames", {16'd0, frame_cnt}, 32'd3);
    // R9: geometry rewritten mid-frame
    phase = "R9 midframe";
    run(40);
    set_geom(5, 1, 4, 3, 1, 2);
    run(96 * 2);
    // R4 and R10: all inversions with the trailing-edge event
    phase = "R4 R10 inverted";
    cfg_ctrl = 6'b111111;
    run(300);
    // R8: disable in mid-frame, then restart
    phase = "R8 disable";
    run(17);
    cfg_ctrl = 6'b111110;
    run(25);
    cfg_ctrl = 6'b000001;
    blank_rgb = 24'h123456;
    run(200);
    // R2: both porches zero
    phase = "R2 zero porch";
    set_geom(3, 0, 0, 2, 0, 0);
    run(100);
    cfg_ctrl = 6'b000000;
    run(3);
    cfg_ctrl = 6'b100001;
    run(60);
    finish_up();
  end

endmodule